// File: doc/BRIEF.md
# Three-Wire Wiper Position Controller

This block is the digital control section of a 100-position digitally trimmed potentiometer. A host drives three slow wires: an active-low select, an active-low step strobe and a direction level. While the block is selected, each high-to-low transition of the strobe moves a saturating tap counter one position up or down. The counter is decoded into a one-hot bus that drives the wiper switches of an external resistor array.

The block also holds a nonvolatile position register. If the host releases select while the strobe is high, the block commits the current position to that register. The write occupies a fixed number of clock cycles, and a busy output stays high for that time. If the host releases select while the strobe is low, the position stays in effect but is not committed. At power-up (`rst_n`) the committed value is loaded back into the counter.

The nonvolatile register has its own clear input, `nv_rst_n`, which represents the initial programming of the cells. Pulsing `rst_n` alone models a power cycle that keeps the stored contents.

Top module: `wiper_ctrl`

## Requirements
- R1: After `rst_n` is released, the block loads the stored position into `tap_pos` on the first clock. Once `nv_rst_n` has been pulsed, that stored position is `INIT_POS` (default 50). After reset, `busy` is 0 and `standby` is 1.
- R2: While `cs_n` is low, a falling edge of `inc_n` changes `tap_pos` by +1 when `up` is 1 and by -1 when `up` is 0. The change appears three clock edges after the input edge.
- R3: While `cs_n` is high, `inc_n` and `up` have no effect on `tap_pos`.
- R4: `tap_pos` never wraps. A step up at `NTAPS-1` (99) leaves it at 99, and a step down at 0 leaves it at 0.
- R5: `tap_sel` is one-hot, and its set bit is bit number `tap_pos`.
- R6: A rising edge of `cs_n` while `inc_n` is high starts a store. `busy` is then high for exactly `STORE_CYCLES` clock cycles, and afterwards the stored value equals the position at the moment of the store. It is observed at the next `rst_n` recall.
- R7: A rising edge of `cs_n` while `inc_n` is low leaves `busy` at 0 and keeps the current position. The stored value is unchanged, so the next recall returns the previously stored position.
- R8: While `busy` is high, activity on `cs_n`, `inc_n` and `up` changes neither `tap_pos` nor the value being stored.
- R9: A rising edge of `inc_n` never steps the counter. `up` may change while the block stays selected, and the next falling edge uses the new direction.
- R10: `standby` is 1 exactly when the synchronized `cs_n` is high and no store is in progress. It is never 1 together with `busy`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low power-up reset; recalls the stored position |
| nv_rst_n | input | 1 | Active-low initialization of the nonvolatile register to `INIT_POS` |
| cs_n | input | 1 | Active-low select, asynchronous |
| inc_n | input | 1 | Step strobe, steps on its falling edge, asynchronous |
| up | input | 1 | Step direction: 1 up, 0 down, asynchronous |
| tap_sel | output | NTAPS | One-hot wiper switch select |
| tap_pos | output | CW | Current tap position |
| busy | output | 1 | Store in progress |
| standby | output | 1 | Deselected and idle |

## Verification
The following properties are checked on every clock:
- `tap_pos` stays in range.
- `tap_sel` is one-hot and agrees with `tap_pos`.
- Apart from the recall cycle, the position moves by at most one step per clock.
- The position is frozen whenever the block is busy or in standby.
- `busy` and `standby` are never high together.

Some behaviours can only be shown by the directed scenarios:
- the direction of each step;
- saturation at both ends;
- the exact length of the busy window;
- the difference between a committed and an uncommitted deselect, which becomes visible only after a later power-up recall returns the stored value.

// File: rtl/wpc_pkg.sv
package wpc_pkg;
   // Store controller states
   typedef enum logic {
      SS_IDLE  = 1'b0,
      SS_WRITE = 1'b1
   } store_state_e;

   // Width needed to count 0..n inclusive
   function automatic int unsigned cnt_width(input int unsigned n);
      return (n < 2) ? 1 : $clog2(n + 1);
   endfunction
endpackage

// File: rtl/wpc_sync.sv
module wpc_sync #(
   parameter int unsigned STAGES  = 2,
   parameter logic        RST_VAL = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   logic [STAGES-1:0] chain;

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("wpc_sync: STAGES must be at least 2");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= {STAGES{RST_VAL}};
      else        chain <= {chain[STAGES-2:0], d};
   end

   assign q = chain[STAGES-1];
endmodule

// File: rtl/wpc_tap_counter.sv
module wpc_tap_counter #(
   parameter int unsigned NTAPS = 100,
   parameter int unsigned CW    = 7
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic [CW-1:0] load_val,
   input  logic          step,
   input  logic          dir_up,
   output logic [CW-1:0] pos
);
   localparam logic [CW-1:0] TOP_POS = CW'(NTAPS - 1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pos <= '0;
      end else if (load) begin
         pos <= load_val;
      end else if (step) begin
         if (dir_up && (pos != TOP_POS))  pos <= pos + 1'b1;
         else if (!dir_up && (pos != '0)) pos <= pos - 1'b1;
      end
   end
endmodule

// File: rtl/wpc_onehot_dec.sv
module wpc_onehot_dec #(
   parameter int unsigned NTAPS = 100,
   parameter int unsigned CW    = 7
) (
   input  logic [CW-1:0]    pos,
   output logic [NTAPS-1:0] sel
);
   generate
      for (genvar i = 0; i < NTAPS; i++) begin : g_tap
         assign sel[i] = (pos == CW'(i));
      end
   endgenerate
endmodule

// File: rtl/wpc_store_ctl.sv
module wpc_store_ctl
   import wpc_pkg::*;
#(
   parameter int unsigned CW           = 7,
   parameter int unsigned STORE_CYCLES = 5_000_000,
   parameter int unsigned INIT_POS     = 50
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          nv_rst_n,
   input  logic          start,
   input  logic [CW-1:0] data,
   output logic          busy,
   output logic [CW-1:0] nv_q
);
   localparam int unsigned TW = cnt_width(STORE_CYCLES);

   store_state_e  state;
   logic [TW-1:0] timer;
   logic [CW-1:0] wr_data;
   logic          wr_en;

   assign busy  = (state == SS_WRITE);
   assign wr_en = busy && (timer == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state   <= SS_IDLE;
         timer   <= '0;
         wr_data <= '0;
      end else begin
         case (state)
            SS_IDLE: if (start) begin
               state   <= SS_WRITE;
               timer   <= TW'(STORE_CYCLES - 1);
               wr_data <= data;
            end
            SS_WRITE: begin
               if (timer == '0) state <= SS_IDLE;
               else             timer <= timer - 1'b1;
            end
            default: state <= SS_IDLE;
         endcase
      end
   end

   // Nonvolatile cells: survive rst_n, cleared only by nv_rst_n
   always_ff @(posedge clk or negedge nv_rst_n) begin
      if (!nv_rst_n)  nv_q <= CW'(INIT_POS);
      else if (wr_en) nv_q <= wr_data;
   end
endmodule

// File: rtl/wiper_ctrl.sv
module wiper_ctrl #(
   parameter int unsigned NTAPS        = 100,
   parameter int unsigned CW           = 7,
   parameter int unsigned STORE_CYCLES = 5_000_000,
   parameter int unsigned INIT_POS     = 50,
   parameter int unsigned SYNC_STAGES  = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             nv_rst_n,
   input  logic             cs_n,
   input  logic             inc_n,
   input  logic             up,
   output logic [NTAPS-1:0] tap_sel,
   output logic [CW-1:0]    tap_pos,
   output logic             busy,
   output logic             standby
);
   generate
      if (NTAPS < 2) begin : g_bad_ntaps
         $error("wiper_ctrl: NTAPS must be at least 2");
      end
      if (NTAPS > (2 ** CW)) begin : g_bad_cw
         $error("wiper_ctrl: CW too narrow for NTAPS");
      end
      if (INIT_POS >= NTAPS) begin : g_bad_init
         $error("wiper_ctrl: INIT_POS out of range");
      end
      if (STORE_CYCLES < 1) begin : g_bad_store
         $error("wiper_ctrl: STORE_CYCLES must be at least 1");
      end
   endgenerate

   logic          s_cs_n, s_inc_n, s_up;
   logic          p_cs_n, p_inc_n;
   logic          recall_q;
   logic          step, store_go;
   logic [CW-1:0] nv_q;

   wpc_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_cs (
      .clk(clk), .rst_n(rst_n), .d(cs_n), .q(s_cs_n));
   wpc_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_inc (
      .clk(clk), .rst_n(rst_n), .d(inc_n), .q(s_inc_n));
   wpc_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_up (
      .clk(clk), .rst_n(rst_n), .d(up), .q(s_up));

   // Previous samples for edge detection; recall flag for power-up load
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         p_cs_n   <= 1'b1;
         p_inc_n  <= 1'b1;
         recall_q <= 1'b1;
      end else begin
         p_cs_n   <= s_cs_n;
         p_inc_n  <= s_inc_n;
         recall_q <= 1'b0;
      end
   end

   assign step     = !s_cs_n && p_inc_n && !s_inc_n && !busy && !recall_q;
   assign store_go = !p_cs_n && s_cs_n && s_inc_n && !busy && !recall_q;

   wpc_tap_counter #(.NTAPS(NTAPS), .CW(CW)) u_cnt (
      .clk(clk), .rst_n(rst_n), .load(recall_q), .load_val(nv_q),
      .step(step), .dir_up(s_up), .pos(tap_pos));

   wpc_onehot_dec #(.NTAPS(NTAPS), .CW(CW)) u_dec (
      .pos(tap_pos), .sel(tap_sel));

   wpc_store_ctl #(.CW(CW), .STORE_CYCLES(STORE_CYCLES), .INIT_POS(INIT_POS)) u_store (
      .clk(clk), .rst_n(rst_n), .nv_rst_n(nv_rst_n), .start(store_go),
      .data(tap_pos), .busy(busy), .nv_q(nv_q));

   assign standby = s_cs_n && !busy;
endmodule

// File: rtl/wiper_ctrl_chk.sv
module wiper_ctrl_chk #(
   parameter int unsigned NTAPS = 100,
   parameter int unsigned CW    = 7
) (
   input logic             clk,
   input logic             rst_n,
   input logic [NTAPS-1:0] tap_sel,
   input logic [CW-1:0]    tap_pos,
   input logic             busy,
   input logic             standby,
   input logic             recall
);
   AST_POS_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      tap_pos < CW'(NTAPS)); // R4

   AST_SEL_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot(tap_sel) && (tap_pos < CW'(NTAPS)) && tap_sel[tap_pos]); // R5

   AST_SINGLE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(recall) |-> (tap_pos == $past(tap_pos)) ||
                         (tap_pos == $past(tap_pos) + 1'b1) ||
                         (tap_pos + 1'b1 == $past(tap_pos))); // R2

   AST_BUSY_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> $stable(tap_pos)); // R8

   AST_DESEL_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
      (standby && !recall) |=> $stable(tap_pos)); // R3

   AST_STANDBY_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      !(busy && standby)); // R10
endmodule

bind wiper_ctrl wiper_ctrl_chk #(.NTAPS(NTAPS), .CW(CW)) u_chk (
   .clk(clk), .rst_n(rst_n), .tap_sel(tap_sel), .tap_pos(tap_pos),
   .busy(busy), .standby(standby), .recall(recall_q));

// File: tb/sim_wiper_ctrl.sv
module sim_wiper_ctrl;
   localparam int unsigned NTAPS = 100;
   localparam int unsigned CW    = 7;
   localparam int unsigned SC    = 16;
   localparam int unsigned INIT  = 50;

   logic             clk = 1'b0;
   logic             rst_n, nv_rst_n, cs_n, inc_n, up;
   logic [NTAPS-1:0] tap_sel;
   logic [CW-1:0]    tap_pos;
   logic             busy, standby;
   int               n_chk = 0;
   int               n_fail = 0;
   bit               done = 1'b0;

   always #2 clk = ~clk;

   wiper_ctrl #(.NTAPS(NTAPS), .CW(CW), .STORE_CYCLES(SC), .INIT_POS(INIT)) u0 (
      .clk(clk), .rst_n(rst_n), .nv_rst_n(nv_rst_n), .cs_n(cs_n),
      .inc_n(inc_n), .up(up), .tap_sel(tap_sel), .tap_pos(tap_pos),
      .busy(busy), .standby(standby));

   task automatic chk(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic settle(input int n);
      repeat (n) @(posedge clk);
      @(negedge clk);
   endtask

   task automatic pulse_inc(input int n);
      for (int i = 0; i < n; i++) begin
         inc_n = 1'b0; settle(4);
         inc_n = 1'b1; settle(4);
      end
   endtask

   task automatic power_cycle();
      rst_n = 1'b0; settle(2);
      rst_n = 1'b1; settle(2);
   endtask

   task automatic t_reset();
      cs_n = 1'b1; inc_n = 1'b1; up = 1'b0;
      rst_n = 1'b0; nv_rst_n = 1'b0; settle(3);
      nv_rst_n = 1'b1; rst_n = 1'b1; settle(2);
      chk("R1 pos", tap_pos, INIT);
      chk("R1 busy", busy, 0);
      chk("R1 standby", standby, 1);
      chk("R5 sel", (tap_sel == (NTAPS'(1) << INIT)) ? 1 : 0, 1);
   endtask

   task automatic t_steps();
      cs_n = 1'b0; settle(4);
      chk("R10 selected", standby, 0);
      up = 1'b1; pulse_inc(3);
      chk("R2 up", tap_pos, INIT + 3);
      chk("R5 sel", tap_sel[INIT + 3], 1);
      up = 1'b0; pulse_inc(2);        // direction change while selected
      chk("R9 dir change", tap_pos, INIT + 1);
      inc_n = 1'b0; settle(4);
      chk("R2 down", tap_pos, INIT);
      inc_n = 1'b1; settle(4);
      chk("R9 rising no step", tap_pos, INIT);
   endtask

   task automatic t_no_store();
      inc_n = 1'b0; settle(4);        // steps to INIT-1
      cs_n = 1'b1; settle(2);
      chk("R7 busy", busy, 0);
      settle(3);
      chk("R7 busy later", busy, 0);
      chk("R7 pos kept", tap_pos, INIT - 1);
      inc_n = 1'b1; settle(4);
      up = 1'b1; pulse_inc(2);
      chk("R3 ignored", tap_pos, INIT - 1);
      chk("R10 standby", standby, 1);
      power_cycle();
      chk("R7 recall old", tap_pos, INIT);
   endtask

   task automatic t_saturate();
      cs_n = 1'b0; settle(4);
      up = 1'b1; pulse_inc(55);
      chk("R4 top", tap_pos, NTAPS - 1);
      chk("R5 sel top", tap_sel[NTAPS-1], 1);
      up = 1'b0; pulse_inc(105);
      chk("R4 bottom", tap_pos, 0);
      chk("R5 sel bottom", tap_sel[0], 1);
   endtask

   task automatic t_store();
      int cnt;
      up = 1'b1; pulse_inc(7);
      chk("R2 up from 0", tap_pos, 7);
      cs_n = 1'b1;
      cnt = 0;
      for (int i = 0; i < 4 * SC; i++) begin
         @(negedge clk);
         if (busy) cnt++;
      end
      chk("R6 busy length", cnt, SC);
      chk("R6 pos", tap_pos, 7);
      power_cycle();
      chk("R6 recall", tap_pos, 7);
   endtask

   task automatic t_busy_ignore();
      cs_n = 1'b0; settle(4);
      up = 1'b1; pulse_inc(2);
      cs_n = 1'b1; settle(4);
      chk("R6 busy high", busy, 1);
      chk("R10 not standby", standby, 0);
      cs_n = 1'b0; inc_n = 1'b0; settle(3);
      inc_n = 1'b1; settle(2);
      cs_n = 1'b1; settle(2);
      chk("R8 pos frozen", tap_pos, 9);
      for (int i = 0; i < 4 * SC && busy; i++) @(negedge clk);
      settle(3);
      chk("R8 busy done", busy, 0);
      chk("R8 pos after", tap_pos, 9);
      power_cycle();
      chk("R8 stored value", tap_pos, 9);
   endtask

   initial begin
      #(4 * 150000);
      if (!done) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog actual=hung expected=done");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      t_reset();
      t_steps();
      t_no_store();
      t_saturate();
      t_store();
      t_busy_ignore();
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule